// File: doc/BRIEF.md
# Clock-Synchronous Variable-Length Serial Transceiver

This block is a full-duplex serial port in which data moves in step with a serial clock. Each frame carries from one to eight data bits. A byte written to the transmit holding register is moved into a shift register, and its bits are driven onto the transmit line. In the same frame the receive line is sampled, bit by bit, into a second shift register. The serial clock has two possible sources. It can come from an internal divider that counts base-timer ticks, and in that case the clock is also driven out. It can instead come from an external clock pin, which is synchronised to the system clock.

Each frame latches a set of per-frame controls: the bit order, the frame length and the receive enable. Line polarity can be inverted for both directions at once. A transmit interrupt marks either the moment the holding register empties or the end of the frame. A receive interrupt marks the arrival of a new word. An overrun flag records a received word that was lost because the previous one was not read in time.

The receiver runs only when the transmitter runs. A frame therefore needs the transmit side enabled and a byte written, even when the port is used only to receive.

Top module: `sync_serial_xcvr`

## Requirements
- R1: With the internal clock source, the serial clock output toggles once every k/2+1 base-timer ticks, where k is an even `div_k`. This gives a full period of k+2 ticks. The clock holds its level while `tick` is 0, and it rests high whenever no frame is running.
- R2: With `use_ext_clk`=1, bits shift on the synchronised edges of `ext_sclk`, and `sclk_out` stays high.
- R3: A frame starts only when `tx_en` is 1 and the transmit holding register holds a written byte. With `tx_en`=0 a written byte stays pending: `busy`=0 and `tx_empty`=0.
- R4: A received word is stored only when `rx_en` was 1 at frame start. With `rx_en`=0 the frame still runs, but `rx_full` stays 0.
- R5: With `irq_on_done`=0, `tx_irq` pulses for one cycle as the holding register is loaded into the shifter, and `busy` is 1 in that cycle. With `irq_on_done`=1, it pulses once the last bit has completed, and `busy` is 0 in that cycle.
- R6: At the end of a frame, `rx_irq` pulses and `rx_data` holds the received bits right-aligned. Bit positions at or above the frame length read 0, so a looped-back frame returns the written byte masked to its length.
- R7: `overrun` is set when a frame completes while `rx_full` is still 1 and no read happens in that cycle. A pulse on `rx_rd` clears `rx_full`, and a pulse on `ovr_clr` clears `overrun`.
- R8: With `msb_first`=0 the first bit sent is data bit 0. With `msb_first`=1 the first bit sent is data bit len-1, where len is the effective frame length. The first bit is on the line from frame start.
- R9: The `txd` pin carries the logical bit XOR `invert`, and the received bit is `rxd` XOR `invert`. The idle logical level is 1.
- R10: A `frame_len` of 1 to 8 sets the number of bits per frame. A value of 0 or above 8 is treated as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Base-timer tick enable for the divider |
| ext_sclk | input | 1 | External serial clock |
| sclk_out | output | 1 | Generated serial clock, idle high |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| use_ext_clk | input | 1 | Select the external clock source |
| msb_first | input | 1 | Bit order select |
| invert | input | 1 | Invert the polarity of both data lines |
| irq_on_done | input | 1 | Transmit interrupt cause select |
| frame_len | input | 4 | Bits per frame |
| div_k | input | 8 | Divider value k |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | 8 | Transmit data |
| rx_rd | input | 1 | Receive buffer read strobe |
| ovr_clr | input | 1 | Clear the overrun flag |
| rx_data | output | 8 | Receive buffer |
| rx_full | output | 1 | Receive buffer holds an unread word |
| overrun | output | 1 | Overrun error flag |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |
| tx_empty | output | 1 | Transmit holding register is empty |
| busy | output | 1 | Frame in progress |

## Verification
The assertions check several rules on every cycle:
- The serial clock rests high between frames and stays high in external mode.
- No frame begins while the transmitter is disabled.
- A receive interrupt always comes with a full buffer.
- The overrun flag holds until it is cleared.
- Interrupts are single-cycle pulses.

Other behaviour needs whole frames, so only the bench scenarios show it. These scenarios run frames through a loopback and cover:
- received values across lengths, bit orders and polarities;
- the exact clock period for a given divisor;
- the timing of the two interrupt causes;
- overrun after two unread frames;
- a transfer clocked from the external pin.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  // one-cycle event strobes derived from the serial clock
  typedef struct packed {
    logic rise;
    logic fall;
  } sclk_edge_t;
endpackage

// File: rtl/ssx_clkgen.sv
module ssx_clkgen
  import ssx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             use_ext,
  input  logic [DIV_W-1:0] div_k,
  input  logic             ext_sclk,
  output logic             sclk_out,
  output sclk_edge_t       edges
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic [2:0]       ext_q;
  logic [DIV_W-1:0] half_m1;
  sclk_edge_t       int_e, ext_e;

  // half period is k/2 + 1 ticks; compare against k/2
  assign half_m1 = div_k >> 1;

  always_comb begin
    cnt_d      = cnt_q;
    sclk_d     = sclk_q;
    int_e.rise = 1'b0;
    int_e.fall = 1'b0;
    if (!run || use_ext) begin
      cnt_d  = '0;
      sclk_d = 1'b1;
    end else if (tick) begin
      if (cnt_q == half_m1) begin
        cnt_d      = '0;
        sclk_d     = ~sclk_q;
        int_e.fall = sclk_q;
        int_e.rise = ~sclk_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
      ext_q  <= 3'b111;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
      ext_q  <= {ext_q[1:0], ext_sclk};
    end
  end

  assign ext_e.rise = ext_q[1] & ~ext_q[2];
  assign ext_e.fall = ~ext_q[1] & ext_q[2];
  assign edges      = use_ext ? ext_e : int_e;
  assign sclk_out   = sclk_q;
endmodule

// File: rtl/ssx_core.sv
module ssx_core
  import ssx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sclk_edge_t        edges,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              msb_first,
  input  logic              invert,
  input  logic              irq_on_done,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              rx_rd,
  input  logic              ovr_clr,
  input  logic              rxd,
  output logic              txbit,
  output logic              busy,
  output logic              tx_empty,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              overrun,
  output logic              tx_irq,
  output logic              rx_irq
);
  logic [DATA_W-1:0] tbuf_q, tbuf_d, tsh_q, tsh_d, rsh_q, rsh_d, rdat_q, rdat_d;
  logic [DATA_W-1:0] load_sh, tnext, rnext;
  logic [LEN_W-1:0]  bitn_q, bitn_d, len_q, len_d, len_in;
  logic tfull_q, tfull_d, busy_q, busy_d, rxon_q, rxon_d, msb_q, msb_d;
  logic txb_q, txb_d, rfull_q, rfull_d, ovr_q, ovr_d, tirq_q, tirq_d, rirq_q, rirq_d;
  logic rbit;

  assign len_in  = (frame_len == '0 || frame_len > LEN_W'(DATA_W)) ? LEN_W'(DATA_W) : frame_len;
  assign load_sh = msb_first ? (tbuf_q << (DATA_W - int'(len_in))) : tbuf_q;
  assign tnext   = msb_q ? (tsh_q << 1) : (tsh_q >> 1);
  assign rbit    = rxd ^ invert;
  assign rnext   = msb_q ? {rsh_q[DATA_W-2:0], rbit} : {rbit, rsh_q[DATA_W-1:1]};

  always_comb begin
    tbuf_d = tbuf_q; tfull_d = tfull_q; tsh_d = tsh_q; rsh_d = rsh_q;
    rdat_d = rdat_q; bitn_d = bitn_q; len_d = len_q; busy_d = busy_q;
    rxon_d = rxon_q; msb_d = msb_q; txb_d = txb_q; rfull_d = rfull_q;
    ovr_d = ovr_q; tirq_d = 1'b0; rirq_d = 1'b0;
    if (tx_wr) begin
      tbuf_d  = tx_wdata;
      tfull_d = 1'b1;
    end
    if (rx_rd)   rfull_d = 1'b0;
    if (ovr_clr) ovr_d   = 1'b0;
    if (!busy_q) begin
      if (tfull_q && tx_en) begin
        busy_d  = 1'b1;
        tfull_d = tx_wr;
        len_d   = len_in;
        msb_d   = msb_first;
        rxon_d  = rx_en;
        bitn_d  = '0;
        rsh_d   = '0;
        tsh_d   = load_sh;
        txb_d   = msb_first ? load_sh[DATA_W-1] : load_sh[0];
        tirq_d  = ~irq_on_done;
      end
    end else if (edges.fall && bitn_q != '0) begin
      tsh_d = tnext;
      txb_d = msb_q ? tnext[DATA_W-1] : tnext[0];
    end else if (edges.rise) begin
      rsh_d  = rnext;
      bitn_d = bitn_q + 1'b1;
      if (bitn_q + 1'b1 == len_q) begin
        busy_d = 1'b0;
        txb_d  = 1'b1;
        tirq_d = irq_on_done;
        if (rxon_q) begin
          rdat_d  = msb_q ? rnext : (rnext >> (DATA_W - int'(len_q)));
          if (rfull_q && !rx_rd) ovr_d = 1'b1;
          rfull_d = 1'b1;
          rirq_d  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbuf_q <= '0; tfull_q <= 1'b0; tsh_q <= '0; rsh_q <= '0; rdat_q <= '0;
      bitn_q <= '0; len_q <= '0; busy_q <= 1'b0; rxon_q <= 1'b0; msb_q <= 1'b0;
      txb_q <= 1'b1; rfull_q <= 1'b0; ovr_q <= 1'b0; tirq_q <= 1'b0; rirq_q <= 1'b0;
    end else begin
      tbuf_q <= tbuf_d; tfull_q <= tfull_d; tsh_q <= tsh_d; rsh_q <= rsh_d; rdat_q <= rdat_d;
      bitn_q <= bitn_d; len_q <= len_d; busy_q <= busy_d; rxon_q <= rxon_d; msb_q <= msb_d;
      txb_q <= txb_d; rfull_q <= rfull_d; ovr_q <= ovr_d; tirq_q <= tirq_d; rirq_q <= rirq_d;
    end
  end

  assign txbit    = txb_q;
  assign busy     = busy_q;
  assign tx_empty = ~tfull_q;
  assign rx_data  = rdat_q;
  assign rx_full  = rfull_q;
  assign overrun  = ovr_q;
  assign tx_irq   = tirq_q;
  assign rx_irq   = rirq_q;
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import ssx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ext_sclk,
  output logic              sclk_out,
  output logic              txd,
  input  logic              rxd,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              use_ext_clk,
  input  logic              msb_first,
  input  logic              invert,
  input  logic              irq_on_done,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [DIV_W-1:0]  div_k,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              rx_rd,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              overrun,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              tx_empty,
  output logic              busy
);
  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  logic       txbit;
  sclk_edge_t edges;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  ssx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .tick     (tick),
    .run      (busy),
    .use_ext  (use_ext_clk),
    .div_k    (div_k),
    .ext_sclk (ext_sclk),
    .sclk_out (sclk_out),
    .edges    (edges)
  );

  ssx_core #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .edges       (edges),
    .tx_en       (tx_en),
    .rx_en       (rx_en),
    .msb_first   (msb_first),
    .invert      (invert),
    .irq_on_done (irq_on_done),
    .frame_len   (frame_len),
    .tx_wr       (tx_wr),
    .tx_wdata    (tx_wdata),
    .rx_rd       (rx_rd),
    .ovr_clr     (ovr_clr),
    .rxd         (rxd),
    .txbit       (txbit),
    .busy        (busy),
    .tx_empty    (tx_empty),
    .rx_data     (rx_data),
    .rx_full     (rx_full),
    .overrun     (overrun),
    .tx_irq      (tx_irq),
    .rx_irq      (rx_irq)
  );

  assign txd = txbit ^ invert;
endmodule

// File: rtl/ssx_chk.sv
module ssx_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic sclk_out,
  input logic use_ext_clk,
  input logic tx_en,
  input logic rx_irq,
  input logic rx_full,
  input logic tx_irq,
  input logic overrun,
  input logic ovr_clr
);
  // R1
  idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_out);

  // R2
  ext_clk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    use_ext_clk |=> sclk_out);

  // R3
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !tx_en) |=> !busy);

  // R6
  rx_irq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_full);

  // R6
  rx_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  // R5
  tx_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);

  // R7
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);
endmodule

bind sync_serial_xcvr ssx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .sclk_out    (sclk_out),
  .use_ext_clk (use_ext_clk),
  .tx_en       (tx_en),
  .rx_irq      (rx_irq),
  .rx_full     (rx_full),
  .tx_irq      (tx_irq),
  .overrun     (overrun),
  .ovr_clr     (ovr_clr)
);

// File: tb/tb_sync_serial_xcvr.sv
module tb_sync_serial_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {len[15:12], msb[11], inv[10], 2'b0, data[7:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h88A5, 16'h803C, 16'h5C1B, 16'h34FF,
    16'h1001, 16'h1CFE, 16'h0896, 16'h705A
  };

  logic clk = 1'b0;
  logic rst_n, tick, ext_sclk, rxd, tx_en, rx_en, use_ext_clk, msb_first, invert;
  logic irq_on_done, tx_wr, rx_rd, ovr_clr;
  logic [3:0] frame_len;
  logic [7:0] div_k, tx_wdata, rx_data;
  logic sclk_out, txd, rx_full, overrun, tx_irq, rx_irq, tx_empty, busy;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rxd = txd;  // loopback at pin level

  sync_serial_xcvr dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ext_sclk(ext_sclk), .sclk_out(sclk_out),
    .txd(txd), .rxd(rxd), .tx_en(tx_en), .rx_en(rx_en), .use_ext_clk(use_ext_clk),
    .msb_first(msb_first), .invert(invert), .irq_on_done(irq_on_done),
    .frame_len(frame_len), .div_k(div_k), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
    .rx_rd(rx_rd), .ovr_clr(ovr_clr), .rx_data(rx_data), .rx_full(rx_full),
    .overrun(overrun), .tx_irq(tx_irq), .rx_irq(rx_irq), .tx_empty(tx_empty), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_wdata = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic wait_busy(input logic v);
    for (int i = 0; i < 5000; i++) begin
      if (busy == v) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_rx_irq();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (rx_irq) break;
    end
  endtask

  task automatic wait_tx_irq();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (tx_irq) break;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1; ext_sclk = 1'b1; tx_en = 1'b1; rx_en = 1'b1;
    use_ext_clk = 1'b0; msb_first = 1'b0; invert = 1'b0; irq_on_done = 1'b0;
    tx_wr = 1'b0; rx_rd = 1'b0; ovr_clr = 1'b0; frame_len = 4'd8; div_k = 8'd4;
    tx_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state (R1, R9, R7, R3)
    check(sclk_out == 1'b1 && busy == 1'b0, "R1 reset clk idle", {sclk_out, busy}, 2'b10);
    check(txd == 1'b1, "R9 reset txd idle", txd, 1);
    check(rx_full == 1'b0 && overrun == 1'b0, "R7 reset flags", {rx_full, overrun}, 0);
    check(tx_empty == 1'b1, "R3 reset tx empty", tx_empty, 1);

    // table of loopback frames (R6, R8, R9, R10)
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] d, exp_v;
      int el;
      logic fb;
      d = VEC[v][7:0];
      el = (VEC[v][15:12] == 0 || VEC[v][15:12] > 8) ? 8 : int'(VEC[v][15:12]);
      exp_v = d & 8'((1 << el) - 1);
      fb = VEC[v][11] ? d[el-1] : d[0];
      @(negedge clk);
      frame_len = VEC[v][15:12]; msb_first = VEC[v][11]; invert = VEC[v][10];
      send(d);
      wait_busy(1'b1);
      check(txd == (fb ^ invert), "R8 R9 first bit on pin", txd, fb ^ invert);
      wait_rx_irq();
      check(rx_data == exp_v, "R6 R10 loopback data", rx_data, exp_v);
      pulse_rd();
    end
    invert = 1'b0; msb_first = 1'b0; frame_len = 4'd8;

    // R3: transmit disabled keeps the byte pending
    tx_en = 1'b0;
    send(8'h77);
    repeat (30) @(negedge clk);
    check(busy == 1'b0 && tx_empty == 1'b0, "R3 disabled no start", {busy, tx_empty}, 0);
    tx_en = 1'b1;
    wait_busy(1'b1);
    check(busy == 1'b1, "R3 start after enable", busy, 1);
    wait_rx_irq();
    pulse_rd();

    // R1: period of k+2 ticks and hold while tick=0
    div_k = 8'd6;
    send(8'h00);
    wait_busy(1'b1);
    for (int i = 0; i < 100 && sclk_out; i++) @(negedge clk);
    begin
      int per;
      per = 0;
      for (int i = 0; i < 100 && !sclk_out; i++) begin @(negedge clk); per++; end
      for (int i = 0; i < 100 && sclk_out; i++) begin @(negedge clk); per++; end
      check(per == 8, "R1 clock period k+2", per, 8);
    end
    begin
      logic s0;
      s0 = sclk_out;
      tick = 1'b0;
      repeat (20) @(negedge clk);
      check(sclk_out == s0 && busy == 1'b1, "R1 hold without tick", sclk_out, s0);
      tick = 1'b1;
    end
    wait_rx_irq();
    pulse_rd();
    div_k = 8'd2;

    // R4: receive disabled
    rx_en = 1'b0;
    send(8'h5A);
    wait_busy(1'b1);
    wait_busy(1'b0);
    repeat (5) @(negedge clk);
    check(rx_full == 1'b0, "R4 no store when rx off", rx_full, 0);
    rx_en = 1'b1;

    // R5: interrupt cause select
    irq_on_done = 1'b0;
    send(8'h11);
    wait_tx_irq();
    check(busy == 1'b1, "R5 irq at load", busy, 1);
    wait_rx_irq(); pulse_rd();
    irq_on_done = 1'b1;
    send(8'h22);
    wait_tx_irq();
    check(busy == 1'b0, "R5 irq at done", busy, 0);
    repeat (3) @(negedge clk);
    pulse_rd();
    irq_on_done = 1'b0;

    // R7: overrun
    send(8'h31);
    wait_rx_irq();
    send(8'h42);
    wait_rx_irq();
    check(overrun == 1'b1, "R7 overrun set", overrun, 1);
    check(rx_data == 8'h42, "R7 latest data kept", rx_data, 8'h42);
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    check(overrun == 1'b0, "R7 overrun cleared", overrun, 0);
    pulse_rd();
    check(rx_full == 1'b0, "R7 read clears full", rx_full, 0);

    // R2: external clock
    use_ext_clk = 1'b1;
    send(8'hC3);
    wait_busy(1'b1);
    begin
      bit hi;
      hi = 1'b1;
      for (int b = 0; b < 8; b++) begin
        ext_sclk = 1'b0; repeat (5) @(negedge clk); hi &= sclk_out;
        ext_sclk = 1'b1; repeat (5) @(negedge clk); hi &= sclk_out;
      end
      check(hi, "R2 sclk_out high in ext mode", hi, 1);
    end
    repeat (5) @(negedge clk);
    check(rx_full == 1'b1 && busy == 1'b0, "R2 ext frame done", {rx_full, busy}, 2'b10);
    check(rx_data == 8'hC3, "R2 ext data", rx_data, 8'hC3);
    pulse_rd();
    use_ext_clk = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule